// File: doc/BRIEF.md
# Serial Port with APB Register Access

This block is a two-wire asynchronous serial port, transmit and receive only, reached through a word-addressed APB slave. Software sets a bit divisor, enables the directions it needs, and moves single bytes through a one-byte holding register in each direction. Frames are eight data bits, no parity, one stop bit, least significant bit first.

The transmit interrupt is an event, not a level. It is raised in the clock where the transmit holding register hands its byte to the shifter, which is the moment the register goes from full to empty. Enabling that interrupt while the register is already empty raises nothing. Driver software must therefore prime its first transfer itself.

Receive and overrun events latch into a write-one-to-clear pending register, and each event has its own enable. Three interrupt lines leave the block: transmit, receive, and the OR of every pending bit.

Top module: `apb_serial_port`

## Requirements
- R1: After reset every register reads zero, txd is high, and txIrq, rxIrq and anyIrq are low.
- R2: Registers are word-aligned: data at 0x00, status at 0x04, control at 0x08, interrupt pending (read) and clear (write) at 0x0C, divisor at 0x10. Every access completes in its access cycle, with pready high and pslverr low.
- R3: The transmitter sends a start bit (low), then data bits 0 to 7, then a stop bit (high). Each bit lasts divisor clocks, and the line idles high.
- R4: Interrupt pending bits are: bit 0 transmit, bit 1 receive, bit 2 transmit overrun, bit 3 receive overrun. Writing 1 to a bit at 0x0C clears it. txIrq follows bit 0, rxIrq follows bit 1, and anyIrq is the OR of all four.
- R5: Pending bit 0 is set only when the transmit holding register drains from full to empty while control bit 2 is set. Setting control bit 2 while the register is empty leaves it clear.
- R6: Writing data while status bit 0 (transmit full) is set discards the byte and sets status bit 2. This also sets pending bit 2 when control bit 4 is set. Writing 1 to status bit 2 clears the flag.
- R7: A received frame loads the receive register, sets status bit 1, and sets pending bit 1 when control bit 3 is set. Reading data returns the byte and clears status bit 1.
- R8: A frame that arrives while status bit 1 is set keeps the old byte and sets status bit 3. It also sets pending bit 3 when control bit 5 is set.
- R9: A received frame whose stop bit samples low is dropped and leaves status bit 1 clear.
- R10: A divisor below 16 holds both directions idle. While that holds, a written byte stays in the holding register.
- R11: Transmission needs control bit 0, and reception needs control bit 1. With control bit 0 clear, a written byte stays in the holding register.
- R12: With control bit 6 set, each transmitted bit lasts one clock, whatever the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and serial clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| txd | output | 1 | Serial out |
| rxd | input | 1 | Serial in |
| txIrq | output | 1 | Transmit pending |
| rxIrq | output | 1 | Receive pending |
| anyIrq | output | 1 | OR of all pending bits |

## Verification
The bench first enables the transmit interrupt with the holding register empty, and expects no pending bit. A level-style design would raise it there at once. Three back-to-back data writes check that the third is dropped rather than overwriting the queued byte. A second frame that arrives before the first is read must leave the first byte in place; a design that overwrote it would return the wrong byte. Further cases cover a bad stop bit, divisors just under the floor, a disabled transmitter and one-clock bits, where a wrong design would emit a frame the serial scoreboard never expected or would never drain the holding register.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int BITCNT_W   = $clog2(FRAME_BITS);
  localparam int CTRL_W     = 7;
  localparam int PEND_W     = 4;

  // control bit positions
  localparam int CB_TXEN  = 0;
  localparam int CB_RXEN  = 1;
  localparam int CB_TXIE  = 2;
  localparam int CB_RXIE  = 3;
  localparam int CB_TXOIE = 4;
  localparam int CB_RXOIE = 5;
  localparam int CB_FAST  = 6;

  // word indices of the registers
  localparam int WI_DATA = 0;
  localparam int WI_STAT = 1;
  localparam int WI_CTRL = 2;
  localparam int WI_PEND = 3;
  localparam int WI_DIV  = 4;

  typedef struct packed {
    logic              txStart;
    logic [BYTE_W-1:0] txByte;
  } phy_cmd_t;

  typedef struct packed {
    logic              txBusy;
    logic              rxDone;
    logic [BYTE_W-1:0] rxByte;
  } phy_evt_t;
endpackage

// File: rtl/serial_port_phy.sv
module serial_port_phy
  import serial_port_pkg::*;
#(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  phy_cmd_t         cmd,
  output phy_evt_t         evt,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxEnable,
  input  logic             fastTx,
  output logic             txd,
  input  logic             rxd
);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_BITS - 1);

  logic                  divOk;
  assign divOk = divisor >= DIV_W'(MIN_DIV);

  // transmit shifter
  logic [FRAME_BITS-1:0] txShift;
  logic [BITCNT_W-1:0]   txBitCnt;
  logic [DIV_W-1:0]      txTick, txLast;
  logic                  txBusy;

  assign txLast = fastTx ? '0 : divisor - DIV_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '1;
      txBitCnt <= '0;
      txTick   <= '0;
      txBusy   <= 1'b0;
    end else if (cmd.txStart) begin
      txShift  <= {1'b1, cmd.txByte, 1'b0};
      txBitCnt <= '0;
      txTick   <= '0;
      txBusy   <= 1'b1;
    end else if (txBusy) begin
      if (txTick >= txLast) begin
        txTick  <= '0;
        txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
        if (txBitCnt == LAST_BIT) txBusy <= 1'b0;
        else txBitCnt <= txBitCnt + BITCNT_W'(1);
      end else begin
        txTick <= txTick + DIV_W'(1);
      end
    end
  end

  assign txd = txShift[0];

  // receive sampler
  logic                rxMeta, rxSync, rxPrev;
  logic                rxActive, rxDoneR;
  logic [BITCNT_W-1:0] rxBitCnt;
  logic [DIV_W-1:0]    rxWait;
  logic [BYTE_W-1:0]   rxShift;
  logic                rxOk;

  assign rxOk = rxEnable && divOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxDoneR  <= 1'b0;
      rxBitCnt <= '0;
      rxWait   <= '0;
      rxShift  <= '0;
    end else begin
      rxDoneR <= 1'b0;
      if (!rxActive) begin
        if (rxOk && rxPrev && !rxSync) begin
          rxActive <= 1'b1;
          rxWait   <= divisor >> 1;
          rxBitCnt <= '0;
        end
      end else if (!rxOk) begin
        rxActive <= 1'b0;
      end else if (rxWait != '0) begin
        rxWait <= rxWait - DIV_W'(1);
      end else begin
        rxWait   <= divisor - DIV_W'(1);
        rxBitCnt <= rxBitCnt + BITCNT_W'(1);
        if (rxBitCnt == '0) begin
          if (rxSync) rxActive <= 1'b0;       // glitch, not a start bit
        end else if (rxBitCnt == LAST_BIT) begin
          rxActive <= 1'b0;
          rxDoneR  <= rxSync;                 // keep only with a high stop bit
        end else begin
          rxShift <= {rxSync, rxShift[BYTE_W-1:1]};
        end
      end
    end
  end

  assign evt.txBusy = txBusy;
  assign evt.rxDone = rxDoneR;
  assign evt.rxByte = rxShift;

  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd) else $error("idle line low");                     // R3
  AST_TX_DIV_GATE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txStart |-> (divOk || fastTx)) else $error("tx below floor");  // R10
  AST_RX_DIV_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (!rxActive && !divOk) |=> !rxActive) else $error("rx below floor"); // R10
endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import serial_port_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output phy_cmd_t          cmd,
  input  phy_evt_t          evt,
  output logic [DIV_W-1:0]  divisor,
  output logic              rxEnable,
  output logic              fastTx,
  output logic [PEND_W-1:0] pend
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              access;
  logic              wrData, wrStat, wrCtrl, wrPend, wrDiv, rdData;

  assign word   = paddr[ADDR_W-1:2];
  assign access = psel && penable;
  assign wrData = access && pwrite && word == WORD_W'(WI_DATA);
  assign wrStat = access && pwrite && word == WORD_W'(WI_STAT);
  assign wrCtrl = access && pwrite && word == WORD_W'(WI_CTRL);
  assign wrPend = access && pwrite && word == WORD_W'(WI_PEND);
  assign wrDiv  = access && pwrite && word == WORD_W'(WI_DIV);
  assign rdData = access && !pwrite && word == WORD_W'(WI_DATA);

  logic                unusedBits;
  assign unusedBits = ^{pwdata[31:DIV_W], paddr[1:0]};

  logic [CTRL_W-1:0] ctrlReg;
  logic [DIV_W-1:0]  divReg;
  logic [BYTE_W-1:0] txBuf, rxBuf;
  logic              txFull, rxFull, txOvr, rxOvr;
  logic              txGo, txLost, rxAccept, rxLost;
  logic [PEND_W-1:0] pendSet, pendClr;

  assign txGo     = txFull && ctrlReg[CB_TXEN] && !evt.txBusy &&
                    (divReg >= DIV_W'(MIN_DIV) || ctrlReg[CB_FAST]);
  assign txLost   = wrData && txFull;
  assign rxAccept = evt.rxDone && (!rxFull || rdData);
  assign rxLost   = evt.rxDone && rxFull && !rdData;

  assign pendSet = {rxLost   && ctrlReg[CB_RXOIE],
                    txLost   && ctrlReg[CB_TXOIE],
                    rxAccept && ctrlReg[CB_RXIE],
                    txGo     && ctrlReg[CB_TXIE]};
  assign pendClr = wrPend ? pwdata[PEND_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divReg  <= '0;
      txBuf   <= '0;
      rxBuf   <= '0;
      txFull  <= 1'b0;
      rxFull  <= 1'b0;
      txOvr   <= 1'b0;
      rxOvr   <= 1'b0;
      pend    <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= pwdata[CTRL_W-1:0];
      if (wrDiv)  divReg  <= pwdata[DIV_W-1:0];

      if (wrData && !txFull) begin
        txBuf  <= pwdata[BYTE_W-1:0];
        txFull <= 1'b1;
      end else if (txGo) begin
        txFull <= 1'b0;
      end

      if (rxAccept) begin
        rxBuf  <= evt.rxByte;
        rxFull <= 1'b1;
      end else if (rdData) begin
        rxFull <= 1'b0;
      end

      if (txLost) txOvr <= 1'b1;
      else if (wrStat && pwdata[2]) txOvr <= 1'b0;
      if (rxLost) rxOvr <= 1'b1;
      else if (wrStat && pwdata[3]) rxOvr <= 1'b0;

      pend <= (pend & ~pendClr) | pendSet;
    end
  end

  always_comb begin
    prdata = '0;
    case (word)
      WORD_W'(WI_DATA): prdata[BYTE_W-1:0] = rxBuf;
      WORD_W'(WI_STAT): prdata[3:0]        = {rxOvr, txOvr, rxFull, txFull};
      WORD_W'(WI_CTRL): prdata[CTRL_W-1:0] = ctrlReg;
      WORD_W'(WI_PEND): prdata[PEND_W-1:0] = pend;
      WORD_W'(WI_DIV):  prdata[DIV_W-1:0]  = divReg;
      default:          prdata = '0;
    endcase
  end

  assign cmd.txStart = txGo;
  assign cmd.txByte  = txBuf;
  assign divisor     = divReg;
  assign rxEnable    = ctrlReg[CB_RXEN];
  assign fastTx      = ctrlReg[CB_FAST];

  AST_TXIRQ_ON_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend[0]) |-> $fell(txFull)) else $error("tx irq without drain");      // R5
  AST_TX_OVR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && txFull) |=> (txOvr && $stable(txBuf))) else $error("tx overrun"); // R6
  AST_RX_KEEP_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rxDone && rxFull && !rdData) |=> (rxOvr && $stable(rxBuf)))
    else $error("rx overrun");                                                   // R8
  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && pwdata[1] && !evt.rxDone) |=> !pend[1]) else $error("w1c");      // R4
endmodule

// File: rtl/apb_serial_port.sv
module apb_serial_port
  import serial_port_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              txd,
  input  logic              rxd,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              anyIrq
);
  phy_cmd_t          cmd;
  phy_evt_t          evt;
  logic [DIV_W-1:0]  divisor;
  logic              rxEnable, fastTx;
  logic [PEND_W-1:0] pend;

  serial_port_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) i_ctrl (
    .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmd(cmd), .evt(evt),
    .divisor(divisor), .rxEnable(rxEnable), .fastTx(fastTx), .pend(pend)
  );

  serial_port_phy #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) i_phy (
    .clk(pclk), .rstN(presetn), .cmd(cmd), .evt(evt), .divisor(divisor),
    .rxEnable(rxEnable), .fastTx(fastTx), .txd(txd), .rxd(rxd)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign txIrq   = pend[0];
  assign rxIrq   = pend[1];
  assign anyIrq  = |pend;
endmodule

// File: tb/test_apb_serial_port.sv
module test_apb_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DIV    = 16;

  logic pclk = 1'b0, presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, txd, txIrq, rxIrq, anyIrq;
  logic rxd = 1'b1;

  apb_serial_port #(.ADDR_W(ADDR_W)) i_apb_serial_port (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .txd(txd), .rxd(rxd), .txIrq(txIrq), .rxIrq(rxIrq), .anyIrq(anyIrq)
  );

  always #(CLK_PERIOD/2) pclk = ~pclk;

  int nChecks = 0, nFails = 0;
  int monPeriod = DIV;
  bit running = 1'b0;
  logic [7:0] txExp[$];
  logic [7:0] got;
  logic [7:0] expB;
  logic stopSeen;
  logic [31:0] rd;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge pclk);
    #1;
  endtask

  task automatic apbWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge pclk); #1 penable = 1'b1;
    @(posedge pclk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge pclk); #1 penable = 1'b1;
    @(negedge pclk); d = prdata;
    @(posedge pclk); #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopBit);
    rxd = 1'b0; tick(DIV);
    for (int k = 0; k < 8; k++) begin rxd = b[k]; tick(DIV); end
    rxd = stopBit; tick(DIV);
    rxd = 1'b1; tick(DIV);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // serial monitor: decodes frames on txd and compares with the expected queue
  initial begin
    forever begin
      @(negedge pclk);
      if (running && txd === 1'b0) begin
        int p;
        p = monPeriod;
        repeat (p/2) @(negedge pclk);
        for (int k = 0; k < 8; k++) begin
          repeat (p) @(negedge pclk);
          got[k] = txd;
        end
        repeat (p) @(negedge pclk);
        stopSeen = txd;
        if (txExp.size() == 0) begin
          check(1'b0, "R3 unexpected frame", {24'd0, got}, 32'hffff_ffff);
        end else begin
          expB = txExp.pop_front();
          check(got == expB && stopSeen == 1'b1, (p == 1) ? "R12 fast frame" : "R3 frame",
                {23'd0, stopSeen, got}, {23'd0, 1'b1, expB});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge pclk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    tick(3);
    presetn = 1'b1;
    tick(2);
    running = 1'b1;

    // R1 / R2 reset values and bus response
    for (int i = 0; i < 5; i++) begin
      apbRead(ADDR_W'(i*4), rd);
      check(rd == 32'd0, "R1 register reset", rd, 32'd0);
    end
    check(txd == 1'b1 && !txIrq && !rxIrq && !anyIrq, "R1 outputs", {28'd0, txd, txIrq, rxIrq, anyIrq}, 32'h8);
    check(pready == 1'b1 && pslverr == 1'b0, "R2 bus response", {30'd0, pready, pslverr}, 32'h2);

    apbWrite(12'h010, DIV);
    apbRead(12'h010, rd);
    check(rd == DIV, "R2 divisor readback", rd, DIV);

    // R5: enabling the tx interrupt with an empty buffer raises nothing
    apbWrite(12'h008, 32'h3F);
    apbRead(12'h008, rd);
    check(rd == 32'h3F, "R2 control readback", rd, 32'h3F);
    tick(4);
    apbRead(12'h00C, rd);
    check(rd == 32'd0, "R5 no irq on enable", rd, 32'd0);

    // R3 / R5 single byte, drain edge raises tx interrupt
    txExp.push_back(8'hA5);
    apbWrite(12'h000, 32'hA5);
    tick(3);
    apbRead(12'h00C, rd);
    check(rd[0] == 1'b1, "R5 irq on drain", rd, 32'h1);
    check(txIrq && anyIrq, "R4 irq outputs", {30'd0, txIrq, anyIrq}, 32'h3);
    apbWrite(12'h00C, 32'h1);
    apbRead(12'h00C, rd);
    check(rd == 32'd0 && !anyIrq, "R4 write one to clear", rd, 32'd0);
    tick(12*DIV);
    check(txExp.size() == 0, "R3 frame delivered", txExp.size(), 0);

    // R6 third back-to-back write dropped
    txExp.push_back(8'h3C);
    txExp.push_back(8'h81);
    apbWrite(12'h000, 32'h3C);
    apbWrite(12'h000, 32'h81);
    apbWrite(12'h000, 32'hEE);
    apbRead(12'h004, rd);
    check(rd[2] == 1'b1 && rd[0] == 1'b1, "R6 overrun flag", rd, 32'h5);
    apbRead(12'h00C, rd);
    check(rd[2] == 1'b1, "R6 overrun irq", rd, 32'h4);
    apbWrite(12'h004, 32'h4);
    apbWrite(12'h00C, 32'hF);
    apbRead(12'h004, rd);
    check(rd[2] == 1'b0, "R6 overrun clear", rd, 32'h1);
    tick(23*DIV);
    check(txExp.size() == 0, "R6 queued byte kept", txExp.size(), 0);
    apbWrite(12'h00C, 32'hF);

    // R7 receive
    sendFrame(8'hC3, 1'b1);
    apbRead(12'h004, rd);
    check(rd[1] == 1'b1, "R7 rx full", rd, 32'h2);
    check(rxIrq && anyIrq, "R7 rx irq", {30'd0, rxIrq, anyIrq}, 32'h3);
    apbRead(12'h000, rd);
    check(rd == 32'hC3, "R7 rx byte", rd, 32'hC3);
    apbRead(12'h004, rd);
    check(rd[1] == 1'b0, "R7 rx cleared by read", rd, 32'h0);
    apbWrite(12'h00C, 32'hF);

    // R8 overrun keeps the older byte
    sendFrame(8'h5A, 1'b1);
    sendFrame(8'hA6, 1'b1);
    apbRead(12'h004, rd);
    check(rd[3] == 1'b1 && rd[1] == 1'b1, "R8 rx overrun flag", rd, 32'hA);
    apbRead(12'h00C, rd);
    check(rd[3] == 1'b1, "R8 rx overrun irq", rd, 32'h8);
    apbRead(12'h000, rd);
    check(rd == 32'h5A, "R8 old byte kept", rd, 32'h5A);
    apbWrite(12'h004, 32'h8);
    apbWrite(12'h00C, 32'hF);

    // R9 low stop bit drops the frame
    sendFrame(8'h55, 1'b0);
    tick(4);
    apbRead(12'h004, rd);
    check(rd[1] == 1'b0, "R9 bad stop dropped", rd, 32'h0);

    // R10 divisor below floor holds transmit
    apbWrite(12'h010, DIV-1);
    apbWrite(12'h000, 32'h77);
    tick(15*DIV);
    apbRead(12'h004, rd);
    check(rd[0] == 1'b1, "R10 tx held below floor", rd, 32'h1);
    sendFrame(8'h12, 1'b1);
    apbRead(12'h004, rd);
    check(rd[1] == 1'b0, "R10 rx held below floor", rd, 32'h1);
    txExp.push_back(8'h77);
    apbWrite(12'h010, DIV);
    tick(12*DIV);
    check(txExp.size() == 0, "R10 released at floor", txExp.size(), 0);

    // R11 transmitter disabled
    apbWrite(12'h008, 32'h3E);
    apbWrite(12'h000, 32'h11);
    tick(12*DIV);
    apbRead(12'h004, rd);
    check(rd[0] == 1'b1, "R11 tx disabled holds", rd, 32'h1);
    txExp.push_back(8'h11);
    apbWrite(12'h008, 32'h3F);
    tick(12*DIV);
    check(txExp.size() == 0, "R11 tx enable releases", txExp.size(), 0);

    // R12 one clock per bit
    monPeriod = 1;
    apbWrite(12'h010, 32'd0);
    apbWrite(12'h008, 32'h41);
    txExp.push_back(8'h96);
    apbWrite(12'h000, 32'h96);
    tick(40);
    check(txExp.size() == 0, "R12 fast frame delivered", txExp.size(), 0);

    finishRun();
  end
endmodule